// File: doc/BRIEF.md
# Configurable GPIO Interrupt Aggregator

This block collects interrupt causes for a small interface chip and presents them on one interrupt pin. One cause comes from a general-purpose input pin, watched either for transitions or for levels. Five more come from internal single-cycle event strobes: remote wake, disconnect, charger detected, attach and over-voltage. Each cause has a sticky status bit that software clears by writing 1, and an enable bit that lets it reach the pin.

Software reaches the block through a simple synchronous register port. It writes on `wr_en` and reads `rdata` one cycle after presenting `addr`. The interrupt pin is driven as a data/output-enable pair, so the pad cell can be used open-drain or push-pull. In push-pull mode the polarity can be chosen, and software can force the pin to a value it picks.

Register map (3-bit address): 0 = pin control (bit 0 trigger type: 0 edge, 1 level; bit 1 synchronised pin level, read-only). 1 = output control (bit 0 push-pull, bit 1 active-low, bit 2 override enable, bit 3 override value, bit 7 soft reset, write-only and read as 0). 2 = enable group A. 3 = enable group B. 4 = status group A. 5 = status group B. All other addresses read 0.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads 0 and the pin is released: `pad_oe`=0 and `pad_o`=0.
- R2: In edge mode, a low-to-high transition of the synchronised pin sets status A bit 7 and a high-to-low transition sets status A bit 6. The status bit is set three clocks after the raw pin changes.
- R3: In level mode, status A bit 7 is set on every cycle the synchronised pin is high and bit 6 on every cycle it is low, so clearing it while the level persists has no lasting effect.
- R4: A one-cycle strobe sets its status bit at the next clock edge. The positions are remote wake at status A bit 3, disconnect at A bit 2, charger at B bit 5, attach at B bit 3 and over-voltage at B bit 1.
- R5: Writing 1 to a status bit clears it and writing 0 leaves it unchanged. When a set and a clear reach the same bit in the same cycle, the bit stays set.
- R6: Enable registers implement only the bits their status register implements (A: 0xCC, B: 0x2A), and unimplemented bits read 0. The interrupt is asserted when any status bit has its enable bit set.
- R7: In open-drain mode (output control bit 0 = 0), `pad_o` is 0 and `pad_oe` equals the asserted state. The polarity bit is ignored.
- R8: In push-pull mode, `pad_oe` is 1 and `pad_o` equals the asserted state XOR the active-low bit. The pad outputs follow the asserted state one clock later.
- R9: With override enabled, the override value replaces the combined interrupt state, and the drive mode and polarity still apply.
- R10: Writing 1 to output control bit 7 returns every status, enable and configuration bit, and the synchroniser, to 0 at that clock edge.
- R11: Pin control bit 1 reads the synchronised level of the input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered from `addr` |
| pin_raw | input | 1 | Asynchronous monitored input pin |
| ev_wake | input | 1 | Remote wake event strobe |
| ev_disc | input | 1 | Disconnect event strobe |
| ev_chg | input | 1 | Charger detected event strobe |
| ev_attach | input | 1 | Attach event strobe |
| ev_ovp | input | 1 | Over-voltage event strobe |
| pad_o | output | 1 | Interrupt pin data |
| pad_oe | output | 1 | Interrupt pin output enable |

## Verification
A lost or stuck status bit shows up on the next read of its status register. If its enable is set, it also shows on the pad one clock after the status change. A wrong drive-mode or polarity register is visible on `pad_o`/`pad_oe` within one clock, because the pad stage is re-registered on every cycle. Errors in the synchroniser or in edge detection move or remove the status set. A cycle-accurate reference model compares every cycle, so an error of even one cycle is caught on the next read or the next interrupt state change.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PIN = 3'd0;
  localparam logic [ADDR_W-1:0] A_OUT = 3'd1;
  localparam logic [ADDR_W-1:0] A_EN1 = 3'd2;
  localparam logic [ADDR_W-1:0] A_EN2 = 3'd3;
  localparam logic [ADDR_W-1:0] A_ST1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_ST2 = 3'd5;

  localparam int B1_RISE = 7;
  localparam int B1_FALL = 6;
  localparam int B1_WAKE = 3;
  localparam int B1_DISC = 2;
  localparam int B2_CHG  = 5;
  localparam int B2_ATT  = 3;
  localparam int B2_OVP  = 1;

  localparam logic [DATA_W-1:0] MASK1 =
    (8'd1 << B1_RISE) | (8'd1 << B1_FALL) | (8'd1 << B1_WAKE) | (8'd1 << B1_DISC);
  localparam logic [DATA_W-1:0] MASK2 =
    (8'd1 << B2_CHG) | (8'd1 << B2_ATT) | (8'd1 << B2_OVP);

  localparam int OUT_PP   = 0;
  localparam int OUT_AL   = 1;
  localparam int OUT_OVE  = 2;
  localparam int OUT_OVV  = 3;
  localparam int OUT_SRST = 7;

  typedef struct packed {
    logic ovr_val;
    logic ovr_en;
    logic active_low;
    logic push_pull;
  } pad_cfg_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pin_raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg  <= '0;
      prev_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], pin_raw};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = shreg[STAGES-1] & ~prev_q;
  assign fall  = ~shreg[STAGES-1] & prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] set_i,
  input  logic         wr_status,
  input  logic         wr_enable,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         pending_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_impl
      logic st_q, en_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          st_q <= 1'b0;
          en_q <= 1'b0;
        end else begin
          st_q <= (st_q & ~(wr_status & wdata[i])) | set_i[i];
          if (wr_enable) en_q <= wdata[i];
        end
      end
      assign status_o[i] = st_q;
      assign enable_o[i] = en_q;
    end else begin : g_tie
      assign status_o[i] = 1'b0;
      assign enable_o[i] = 1'b0;
    end
  end

  assign pending_o = |(status_o & enable_o);
endmodule

// File: rtl/irq_pad_drive.sv
module irq_pad_drive
  import irq_agg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     pending,
  input  pad_cfg_t cfg,
  output logic     pad_o,
  output logic     pad_oe
);
  logic asserted;
  assign asserted = cfg.ovr_en ? cfg.ovr_val : pending;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pad_o  <= 1'b0;
      pad_oe <= 1'b0;
    end else if (cfg.push_pull) begin
      pad_o  <= asserted ^ cfg.active_low;
      pad_oe <= 1'b1;
    end else begin
      pad_o  <= 1'b0;
      pad_oe <= asserted;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              pin_raw,
  input  logic              ev_wake,
  input  logic              ev_disc,
  input  logic              ev_chg,
  input  logic              ev_attach,
  input  logic              ev_ovp,
  output logic              pad_o,
  output logic              pad_oe
);
  logic soft_clr;
  logic pin_lvl, pin_rise, pin_fall;
  logic trig_lvl_q;
  pad_cfg_t cfg_q;
  logic [DATA_W-1:0] set1, set2, st1, st2, en1, en2;
  logic pend1, pend2;
  logic [DATA_W-1:0] rdata_q;

  assign soft_clr = wr_en && (addr == A_OUT) && wdata[OUT_SRST];

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .clr(soft_clr), .pin_raw(pin_raw),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      trig_lvl_q <= 1'b0;
      cfg_q      <= '0;
    end else if (wr_en) begin
      if (addr == A_PIN) trig_lvl_q <= wdata[0];
      if (addr == A_OUT) begin
        cfg_q.push_pull  <= wdata[OUT_PP];
        cfg_q.active_low <= wdata[OUT_AL];
        cfg_q.ovr_en     <= wdata[OUT_OVE];
        cfg_q.ovr_val    <= wdata[OUT_OVV];
      end
    end
  end

  always_comb begin
    set1 = '0;
    set2 = '0;
    set1[B1_RISE] = trig_lvl_q ? pin_lvl  : pin_rise;
    set1[B1_FALL] = trig_lvl_q ? ~pin_lvl : pin_fall;
    set1[B1_WAKE] = ev_wake;
    set1[B1_DISC] = ev_disc;
    set2[B2_CHG]  = ev_chg;
    set2[B2_ATT]  = ev_attach;
    set2[B2_OVP]  = ev_ovp;
  end

  irq_status_bank #(.W(DATA_W), .MASK(MASK1)) u_bank1 (
    .clk(clk), .rst(rst), .clr(soft_clr), .set_i(set1),
    .wr_status(wr_en && addr == A_ST1), .wr_enable(wr_en && addr == A_EN1),
    .wdata(wdata), .status_o(st1), .enable_o(en1), .pending_o(pend1)
  );

  irq_status_bank #(.W(DATA_W), .MASK(MASK2)) u_bank2 (
    .clk(clk), .rst(rst), .clr(soft_clr), .set_i(set2),
    .wr_status(wr_en && addr == A_ST2), .wr_enable(wr_en && addr == A_EN2),
    .wdata(wdata), .status_o(st2), .enable_o(en2), .pending_o(pend2)
  );

  irq_pad_drive u_pad (
    .clk(clk), .rst(rst), .clr(soft_clr), .pending(pend1 | pend2),
    .cfg(cfg_q), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      rdata_q <= '0;
    end else begin
      unique case (addr)
        A_PIN:   rdata_q <= {{(DATA_W-2){1'b0}}, pin_lvl, trig_lvl_q};
        A_OUT:   rdata_q <= {{(DATA_W-4){1'b0}}, cfg_q.ovr_val, cfg_q.ovr_en,
                             cfg_q.active_low, cfg_q.push_pull};
        A_EN1:   rdata_q <= en1;
        A_EN2:   rdata_q <= en2;
        A_ST1:   rdata_q <= st1;
        A_ST2:   rdata_q <= st2;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              soft_clr,
  input logic [DATA_W-1:0] st1,
  input logic [DATA_W-1:0] set1,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              pad_o,
  input logic              pad_oe,
  input pad_cfg_t          cfg
);
  logic [DATA_W-1:0] clr1;
  assign clr1 = (wr_en && addr == A_ST1) ? wdata : '0;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!pad_oe && !pad_o && st1 == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
    !soft_clr |=> ((st1 & $past(set1)) == $past(set1)));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !soft_clr |=> ((($past(st1) & ~$past(clr1)) & ~st1) == '0));

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (rst)
    pad_o |-> pad_oe);

  assert_pp_drives_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg.push_pull && !soft_clr) |=> pad_oe);

  assert_override_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg.push_pull && !cfg.active_low && cfg.ovr_en && !soft_clr) |=> (pad_o == $past(cfg.ovr_val)));

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (rst)
    soft_clr |=> (st1 == '0 && cfg == '0));
endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
  .clk(clk), .rst(rst), .soft_clr(soft_clr), .st1(st1), .set1(set1),
  .wr_en(wr_en), .addr(addr), .wdata(wdata), .pad_o(pad_o), .pad_oe(pad_oe),
  .cfg(cfg_q)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic pin_raw = 0, ev_wake = 0, ev_disc = 0, ev_chg = 0, ev_attach = 0, ev_ovp = 0;
  logic pad_o, pad_oe;

  irq_aggregator dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_raw(pin_raw), .ev_wake(ev_wake), .ev_disc(ev_disc), .ev_chg(ev_chg),
    .ev_attach(ev_attach), .ev_ovp(ev_ovp), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic m_s1, m_s2, m_prev, m_trig, m_pp, m_al, m_ove, m_ovv;
  logic [7:0] m_en1, m_en2, m_st1, m_st2, m_rdata;
  logic m_pad_o, m_pad_oe;
  string pad_tag, rd_tag;

  function automatic logic [7:0] rd_value(input logic [2:0] a);
    case (a)
      3'd0: return {6'b0, m_s2, m_trig};
      3'd1: return {4'b0, m_ovv, m_ove, m_al, m_pp};
      3'd2: return m_en1;
      3'd3: return m_en2;
      3'd4: return m_st1;
      3'd5: return m_st2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_clear();
    {m_s1, m_s2, m_prev, m_trig, m_pp, m_al, m_ove, m_ovv} = '0;
    {m_en1, m_en2, m_st1, m_st2, m_rdata} = '0;
    m_pad_o = 0; m_pad_oe = 0;
  endtask

  task automatic model_step();
    logic a, rise, fall;
    logic [7:0] s1v, s2v, c1, c2;
    if (rst || (wr_en && addr == 3'd1 && wdata[7])) begin
      model_clear();
      pad_tag = "R10"; rd_tag = "R10";
      return;
    end
    a = m_ove ? m_ovv : |((m_st1 & m_en1) | (m_st2 & m_en2));
    pad_tag = m_ove ? "R9" : (m_pp ? "R8" : "R7");
    m_pad_o  = m_pp ? (a ^ m_al) : 1'b0;
    m_pad_oe = m_pp ? 1'b1 : a;
    m_rdata  = rd_value(addr);
    rd_tag = (addr >= 3'd4) ? "R5" : (addr == 3'd0 ? "R11" : "R6");
    rise = m_s2 & ~m_prev;
    fall = ~m_s2 & m_prev;
    s1v = {m_trig ? m_s2 : rise, m_trig ? ~m_s2 : fall, 2'b0, ev_wake, ev_disc, 2'b0};
    s2v = {2'b0, ev_chg, 1'b0, ev_attach, 1'b0, ev_ovp, 1'b0};
    c1 = (wr_en && addr == 3'd4) ? wdata : 8'h00;
    c2 = (wr_en && addr == 3'd5) ? wdata : 8'h00;
    m_st1 = ((m_st1 & ~c1) | s1v) & 8'hCC;
    m_st2 = ((m_st2 & ~c2) | s2v) & 8'h2A;
    if (wr_en && addr == 3'd2) m_en1 = wdata & 8'hCC;
    if (wr_en && addr == 3'd3) m_en2 = wdata & 8'h2A;
    if (wr_en && addr == 3'd0) m_trig = wdata[0];
    if (wr_en && addr == 3'd1) {m_ovv, m_ove, m_al, m_pp} = wdata[3:0];
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_raw;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: inputs already driven at negedge; check after the edge
  task automatic tick(input logic w, input logic [2:0] a, input logic [7:0] d);
    wr_en = w; addr = a; wdata = d;
    model_step();
    @(negedge clk);
    check({pad_tag, " pad_o"},  {7'b0, pad_o},  {7'b0, m_pad_o});
    check({pad_tag, " pad_oe"}, {7'b0, pad_oe}, {7'b0, m_pad_oe});
    check({rd_tag, " rdata"}, rdata, m_rdata);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 3'd0, 8'h00);
  endtask

  task automatic read_expect(input logic [2:0] a, input logic [7:0] exp, input string tag);
    tick(0, a, 8'h00);
    check(tag, rdata, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1;
    tick(0, 3'd0, 8'h00);
    rst = 0;
    // R1 reset state
    read_expect(3'd4, 8'h00, "R1 status A");
    read_expect(3'd1, 8'h00, "R1 output control");
    check("R1 pad_oe", {7'b0, pad_oe}, 8'h00);
    check("R1 pad_o", {7'b0, pad_o}, 8'h00);
    // R2 edge mode
    pin_raw = 1; idle(4);
    read_expect(3'd4, 8'h80, "R2 rising");
    read_expect(3'd0, 8'h02, "R11 level high");
    pin_raw = 0; idle(4);
    read_expect(3'd4, 8'hC0, "R2 falling");
    read_expect(3'd0, 8'h00, "R11 level low");
    // R5 write-one-to-clear
    tick(1, 3'd4, 8'h40);
    read_expect(3'd4, 8'h80, "R5 clear one bit");
    tick(1, 3'd4, 8'h00);
    read_expect(3'd4, 8'h80, "R5 write zero");
    tick(1, 3'd4, 8'h80);
    read_expect(3'd4, 8'h00, "R5 clear last");
    // R4 strobes
    {ev_wake, ev_disc, ev_chg, ev_attach, ev_ovp} = 5'b11111;
    tick(0, 3'd0, 8'h00);
    {ev_wake, ev_disc, ev_chg, ev_attach, ev_ovp} = 5'b00000;
    read_expect(3'd4, 8'h0C, "R4 group A");
    read_expect(3'd5, 8'h2A, "R4 group B");
    // R5 set and clear same cycle
    tick(1, 3'd4, 8'h04);
    ev_wake = 1;
    tick(1, 3'd4, 8'hFF);
    ev_wake = 0;
    read_expect(3'd4, 8'h08, "R5 event wins");
    // R6 enables
    tick(1, 3'd2, 8'hFF);
    read_expect(3'd2, 8'hCC, "R6 enable mask A");
    tick(1, 3'd3, 8'hFF);
    read_expect(3'd3, 8'h2A, "R6 enable mask B");
    check("R7 open-drain oe", {7'b0, pad_oe}, 8'h01);
    check("R7 open-drain data", {7'b0, pad_o}, 8'h00);
    tick(1, 3'd1, 8'h02);
    idle(1);
    check("R7 polarity ignored", {6'b0, pad_oe, pad_o}, 8'h02);
    // R8 push-pull
    tick(1, 3'd1, 8'h01); idle(1);
    check("R8 active high", {6'b0, pad_oe, pad_o}, 8'h03);
    tick(1, 3'd1, 8'h03); idle(1);
    check("R8 active low", {6'b0, pad_oe, pad_o}, 8'h02);
    // R9 override
    tick(1, 3'd4, 8'hFF); tick(1, 3'd5, 8'hFF);
    tick(1, 3'd1, 8'h0D); idle(1);
    check("R9 override forced", {6'b0, pad_oe, pad_o}, 8'h03);
    tick(1, 3'd1, 8'h05); idle(1);
    check("R9 override idle", {6'b0, pad_oe, pad_o}, 8'h02);
    // R3 level mode
    tick(1, 3'd0, 8'h01);
    pin_raw = 1; idle(4);
    tick(1, 3'd4, 8'hC0);
    read_expect(3'd4, 8'h80, "R3 level re-sets");
    // R10 soft reset
    tick(1, 3'd1, 8'h80);
    read_expect(3'd4, 8'h00, "R10 status cleared");
    read_expect(3'd2, 8'h00, "R10 enable cleared");
    read_expect(3'd1, 8'h00, "R10 config cleared");
    check("R10 pad released", {6'b0, pad_oe, pad_o}, 8'h00);
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic [2:0] a;
      if ($urandom % 6 == 0) pin_raw = ~pin_raw;
      ev_wake = ($urandom % 8 == 0); ev_disc = ($urandom % 8 == 0);
      ev_chg = ($urandom % 8 == 0); ev_attach = ($urandom % 8 == 0);
      ev_ovp = ($urandom % 8 == 0);
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 3'd1 && ($urandom % 64 != 0)) d[7] = 1'b0;
      tick(($urandom % 2) == 0, a, d);
    end
    {ev_wake, ev_disc, ev_chg, ev_attach, ev_ovp} = 5'b00000;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule